// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block links two bidirectional data buses, called A and B, through two storage registers that work on their own. The forward register samples bus A and presents its contents toward bus B. The reverse register samples bus B and presents its contents toward bus A. Each register has its own clock, an active-low capture enable and an active-low drive enable. A register updates only on a rising edge of its own clock while its capture enable is low. Its contents appear on the opposite bus only while its drive enable is low.

The top level is built for synthesis. Each bus is split into a data input, a data output and a drive-enable output, and a pad ring or an enclosing wrapper resolves them into a tri-stated net. A build-time parameter picks the output polarity. With it cleared, the block passes data through unchanged. With it set, the block drives the bitwise complement of the stored value. The registers always keep the value that was actually seen on the bus.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high reset, sampled on each direction's own clock, clears that direction's register to all zeros. After reset, an enabled output therefore shows 0x00 when POL_INVERT=0 and 0xFF when POL_INVERT=1.
- R2: On a rising edge of `ab_clk` with `ab_cap_n` low, the forward register loads `a_in`. From the next cycle, `b_out` carries that value while `ab_drv_n` is low.
- R3: On a rising edge where a direction's capture enable is high, that direction's register keeps its previous value.
- R4: On a rising edge of `ba_clk` with `ba_cap_n` low, the reverse register loads `b_in`. From the next cycle, `a_out` carries that value while `ba_drv_n` is low.
- R5: `b_oe` is 1 exactly when `ab_drv_n` is low, and `a_oe` is 1 exactly when `ba_drv_n` is low, with no clock delay. When the enable is 0, the bus is high-impedance.
- R6: The drive enable has no effect on the stored data. A value captured while the output is disabled appears unchanged once the output is enabled again.
- R7: With POL_INVERT=1, each enabled output equals the bitwise complement of the value captured from the opposite bus. With POL_INVERT=0, it equals that value unchanged.
- R8: The two directions are independent. Both can capture in the same cycle, and blocking one direction's capture does not stop the other's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ab_clk | input | 1 | Clock of the A-to-B register |
| ba_clk | input | 1 | Clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, applied in each clock domain |
| ab_cap_n | input | 1 | Active-low capture enable, A-to-B |
| ba_cap_n | input | 1 | Active-low capture enable, B-to-A |
| ab_drv_n | input | 1 | Active-low drive enable for bus B |
| ba_drv_n | input | 1 | Active-low drive enable for bus A |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds two copies at WIDTH=8: one with POL_INVERT=0 and one with POL_INVERT=1. Both copies get the same stimulus, so every complemented output can be compared with the same captured value that the true-polarity copy shows. A single clock feeds both direction clocks. This makes simultaneous captures in both directions occur on every edge where both enables are low. Per-direction capture and drive enables then separate the two paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned MAX_WIDTH = 64;
    localparam int unsigned DIR_COUNT = 2;

    typedef enum logic [0:0] {
        DIR_A_TO_B = 1'b0,
        DIR_B_TO_A = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic cap_n;
        logic drv_n;
    } dir_ctrl_t;

    function automatic logic [MAX_WIDTH-1:0] apply_polarity(
        input logic [MAX_WIDTH-1:0] value,
        input bit                   invert
    );
        return invert ? ~value : value;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!cap_n) begin
            q <= d;
        end
    end

    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cap_n |=> $stable(q));

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_n |=> (q == $past(d)));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/xcvr_bus_driver.sv
module xcvr_bus_driver #(
    parameter int unsigned WIDTH      = 8,
    parameter bit          POL_INVERT = 1'b0
) (
    input  logic             drv_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] out,
    output logic             oe
);
    import xcvr_pkg::*;

    logic [MAX_WIDTH-1:0] wide_held;
    logic [MAX_WIDTH-1:0] wide_out;

    always_comb begin
        wide_held            = '0;
        wide_held[WIDTH-1:0] = held;
        wide_out             = apply_polarity(wide_held, POL_INVERT);
    end

    assign out = wide_out[WIDTH-1:0];
    assign oe  = ~drv_n;

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int unsigned WIDTH      = 8,
    parameter bit          POL_INVERT = 1'b0
) (
    input  logic             ab_clk,
    input  logic             ba_clk,
    input  logic             rst,
    input  logic             ab_cap_n,
    input  logic             ba_cap_n,
    input  logic             ab_drv_n,
    input  logic             ba_drv_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    import xcvr_pkg::*;

    localparam logic [WIDTH-1:0] POL_MASK = POL_INVERT ? {WIDTH{1'b1}} : '0;

    logic      [DIR_COUNT-1:0]            dir_clk;
    dir_ctrl_t [DIR_COUNT-1:0]            dir_ctl;
    logic      [DIR_COUNT-1:0][WIDTH-1:0] dir_src;
    logic      [DIR_COUNT-1:0][WIDTH-1:0] dir_held;
    logic      [DIR_COUNT-1:0][WIDTH-1:0] dir_out;
    logic      [DIR_COUNT-1:0]            dir_oe;

    assign dir_clk[DIR_A_TO_B] = ab_clk;
    assign dir_clk[DIR_B_TO_A] = ba_clk;
    assign dir_ctl[DIR_A_TO_B] = '{cap_n: ab_cap_n, drv_n: ab_drv_n};
    assign dir_ctl[DIR_B_TO_A] = '{cap_n: ba_cap_n, drv_n: ba_drv_n};
    assign dir_src[DIR_A_TO_B] = a_in;
    assign dir_src[DIR_B_TO_A] = b_in;

    for (genvar g = 0; g < DIR_COUNT; g++) begin : g_dir
        xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (dir_clk[g]),
            .rst   (rst),
            .cap_n (dir_ctl[g].cap_n),
            .d     (dir_src[g]),
            .q     (dir_held[g])
        );

        xcvr_bus_driver #(.WIDTH(WIDTH), .POL_INVERT(POL_INVERT)) u_drv (
            .drv_n (dir_ctl[g].drv_n),
            .held  (dir_held[g]),
            .out   (dir_out[g]),
            .oe    (dir_oe[g])
        );

        // R7
        polarity_chk: assert property (@(posedge dir_clk[g]) disable iff (rst)
            dir_oe[g] |-> ((dir_out[g] ^ dir_held[g]) == POL_MASK));
    end

    assign b_out = dir_out[DIR_A_TO_B];
    assign b_oe  = dir_oe[DIR_A_TO_B];
    assign a_out = dir_out[DIR_B_TO_A];
    assign a_oe  = dir_oe[DIR_B_TO_A];

    // R6
    drive_keeps_data_chk: assert property (@(posedge ab_clk) disable iff (rst)
        (ab_cap_n && $changed(ab_drv_n)) |=> $stable(dir_held[DIR_A_TO_B]));

endmodule

// File: tb/dual_reg_xcvr_test.sv
module dual_reg_xcvr_test;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ab_cap_n = 1'b1, ba_cap_n = 1'b1;
    logic ab_drv_n = 1'b0, ba_drv_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;

    logic [W-1:0] a_out, b_out, ia_out, ib_out;
    logic a_oe, b_oe, ia_oe, ib_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_reg_xcvr #(.WIDTH(W), .POL_INVERT(1'b0)) uut (
        .ab_clk(clk), .ba_clk(clk), .rst(rst),
        .ab_cap_n(ab_cap_n), .ba_cap_n(ba_cap_n),
        .ab_drv_n(ab_drv_n), .ba_drv_n(ba_drv_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    dual_reg_xcvr #(.WIDTH(W), .POL_INVERT(1'b1)) uut_inv (
        .ab_clk(clk), .ba_clk(clk), .rst(rst),
        .ab_cap_n(ab_cap_n), .ba_cap_n(ba_cap_n),
        .ab_drv_n(ab_drv_n), .ba_drv_n(ba_drv_n),
        .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
        .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe)
    );

    // behavioural reference: what each direction has captured
    logic [W-1:0] m_ab = '0, m_ba = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (!ab_cap_n) m_ab <= a_in;
            if (!ba_cap_n) m_ba <= b_in;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5 b_oe", {7'd0, b_oe}, {7'd0, ~ab_drv_n});
        chk("R5 a_oe", {7'd0, a_oe}, {7'd0, ~ba_drv_n});
        chk("R5 inv b_oe", {7'd0, ib_oe}, {7'd0, ~ab_drv_n});
        chk("R5 inv a_oe", {7'd0, ia_oe}, {7'd0, ~ba_drv_n});
        if (!ab_drv_n) begin
            chk("R2 b_out", b_out, m_ab);
            chk("R7 inv b_out", ib_out, ~m_ab);
        end
        if (!ba_drv_n) begin
            chk("R4 a_out", a_out, m_ba);
            chk("R7 inv a_out", ia_out, ~m_ba);
        end
    endtask

    task automatic step(input logic cab, input logic cba, input logic dab, input logic dba,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        compare_all();
        ab_cap_n = cab; ba_cap_n = cba;
        ab_drv_n = dab; ba_drv_n = dba;
        a_in = av; b_in = bv;
    endtask

    task automatic peek();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) step(1, 1, 0, 0, 8'h5A, 8'hC3);
        @(negedge clk);
        rst = 1'b0;
        peek();
        // R1: cleared registers, true and complemented views
        chk("R1 b_out", b_out, 8'h00);
        chk("R1 a_out", a_out, 8'h00);
        chk("R1 inv b_out", ib_out, 8'hFF);
        chk("R1 inv a_out", ia_out, 8'hFF);

        // R8: both directions capture on the same edge
        step(0, 0, 0, 0, 8'h3C, 8'hA5);
        step(1, 1, 0, 0, 8'h01, 8'h02);
        peek();
        chk("R8 b_out", b_out, 8'h3C);
        chk("R8 a_out", a_out, 8'hA5);
        chk("R3 hold b_out", b_out, 8'h3C);

        // R3 blocked forward capture, R8 reverse still captures
        step(1, 0, 0, 0, 8'hFF, 8'h11);
        peek();
        chk("R3 blocked b_out", b_out, 8'h3C);
        chk("R3 inv blocked b_out", ib_out, 8'hC3);
        chk("R8 a_out independent", a_out, 8'h11);

        // R5 outputs disabled, R6 capture continues behind them
        step(0, 0, 1, 1, 8'h77, 8'h88);
        peek();
        chk("R5 b_oe off", {7'd0, b_oe}, 8'h00);
        chk("R5 a_oe off", {7'd0, a_oe}, 8'h00);
        step(1, 1, 0, 0, 8'h00, 8'h00);
        peek();
        chk("R6 b_out", b_out, 8'h77);
        chk("R6 a_out", a_out, 8'h88);
        chk("R7 inv b_out", ib_out, 8'h88);

        for (int i = 0; i < 400; i++) begin
            step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 8'($urandom), 8'($urandom));
        end
        peek();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule